// File: doc/BRIEF.md
# Mode Register Command Front-End

This block gives software a small APB register window for starting one mode-register access to an external memory device at a time. Software first programs the access and then starts it. It writes the access kind (read or write) and a one-hot rank select into the first control word. It writes the mode-register number and, for a write, the data byte into the second control word. A separate APB write then sets the start bit in the first control word. That bit is never stored: it reads back as zero.

The start produces a one-cycle request strobe on a downstream command port. The kind, rank, register number and data stay on that port without change until the port returns an acknowledge. A busy flag in the status word is high from the start until that acknowledge. While busy is high, every write to either control word is dropped, and a second start is dropped too. Software therefore has to poll busy, program the access and then start it, in that order.

Top module: `mrcmd_frontend`

## Requirements
- R1: After synchronous reset, both control words and the status word read as 0 and `req_valid` is low.
- R2: Offset 0x10 is the first control word. Bit 0 stores the access kind, where 1 means a mode-register read. Bits [5:4] store the rank select. Bit 31 is the start bit and always reads back as 0. All other bits read as 0.
- R3: Offset 0x14 is the second control word. Bits [15:8] store the mode-register number and bits [7:0] store the write data. Both read back as written.
- R4: An accepted write to offset 0x10 with bit 31 set drives `req_valid` high for exactly one cycle, in the cycle after the APB access phase. In that same cycle busy is set. The command fields carry the values written in that same transfer.
- R5: `req_is_read`, `req_rank`, `req_mr_addr` and `req_wdata` do not change while busy is high.
- R6: Busy clears in the cycle after a cycle in which busy and `req_ack` are both high. An acknowledge while busy is low has no effect.
- R7: While busy is high, writes to offsets 0x10 and 0x14 are ignored, including a write that sets the start bit.
- R8: Offset 0x18 is the status word and shows busy in bit 0. Writes to it have no effect.
- R9: `pready` is always high. `pslverr` is high in the access phase of any transfer to an offset other than 0x10, 0x14 or 0x18, and such a write changes nothing.
- R10: A control-word write whose access phase falls in the same cycle as the acknowledge is ignored, because busy is still high in that cycle. The same write issued one transfer later is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access phase |
| pready | output | 1 | APB ready, tied high |
| pslverr | output | 1 | APB error for unmapped offsets |
| req_valid | output | 1 | One-cycle request strobe to the command port |
| req_is_read | output | 1 | 1 = mode-register read, 0 = write |
| req_rank | output | 2 | One-hot rank select |
| req_mr_addr | output | 8 | Mode-register number |
| req_wdata | output | 8 | Mode-register write data |
| req_ack | input | 1 | Completion acknowledge from the command port |

## Verification
The acknowledge that ends a transaction can arrive in the same clock cycle as the access phase of an APB write to a control word. The bench provokes this by raising `req_ack` on the same falling edge that raises `penable` for a write to the second control word. It then reads that word back, and expects the old contents, because busy was still high at that edge. A retry of the same write must then land. The bench also sends a start that is still gated while busy and an acknowledge that arrives while idle, and judges both by readback and by a count of request strobes.

// File: rtl/mrcmd_pkg.sv
package mrcmd_pkg;

  // Register offsets (byte addresses within the block window)
  localparam logic [31:0] OFS_CTL0 = 32'h0000_0010;
  localparam logic [31:0] OFS_CTL1 = 32'h0000_0014;
  localparam logic [31:0] OFS_STAT = 32'h0000_0018;

  // Field geometry
  localparam int KIND_BIT = 0;
  localparam int RANK_LSB = 4;
  localparam int RANK_W   = 2;
  localparam int GO_BIT   = 31;
  localparam int WD_LSB   = 0;
  localparam int WD_W     = 8;
  localparam int MRA_LSB  = 8;
  localparam int MRA_W    = 8;
  localparam int BUSY_BIT = 0;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_CTL0,
    SEL_CTL1,
    SEL_STAT
  } csr_sel_e;

  typedef struct packed {
    logic              is_read;
    logic [RANK_W-1:0] rank;
    logic [MRA_W-1:0]  mra;
    logic [WD_W-1:0]   wdata;
  } mr_cmd_t;

endpackage

// File: rtl/mrcmd_csr.sv
module mrcmd_csr
  import mrcmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic              busy,
  output logic [31:0]       prdata,
  output logic              pslverr,
  output mr_cmd_t           cmd,
  output logic              launch
);

  csr_sel_e    sel;
  logic        setup_ph;
  logic        access_ph;
  logic        wr_ok;
  logic [31:0] rd_word;
  logic        unused_wbits;

  assign setup_ph  = psel && !penable;
  assign access_ph = psel && penable;

  // Address decode: exact word match only
  always_comb begin
    if (paddr == OFS_CTL0[ADDR_W-1:0])      sel = SEL_CTL0;
    else if (paddr == OFS_CTL1[ADDR_W-1:0]) sel = SEL_CTL1;
    else if (paddr == OFS_STAT[ADDR_W-1:0]) sel = SEL_STAT;
    else                                    sel = SEL_NONE;
  end

  // Writes land only when no transaction is outstanding
  assign wr_ok  = access_ph && pwrite && !busy;
  assign launch = wr_ok && (sel == SEL_CTL0) && pwdata[GO_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_CTL0) begin
        cmd.is_read <= pwdata[KIND_BIT];
        cmd.rank    <= pwdata[RANK_LSB +: RANK_W];
      end
      if (sel == SEL_CTL1) begin
        cmd.mra   <= pwdata[MRA_LSB +: MRA_W];
        cmd.wdata <= pwdata[WD_LSB +: WD_W];
      end
    end
  end

  // Readback word; the start bit is never stored
  always_comb begin
    rd_word = '0;
    case (sel)
      SEL_CTL0: begin
        rd_word[KIND_BIT]             = cmd.is_read;
        rd_word[RANK_LSB +: RANK_W]   = cmd.rank;
      end
      SEL_CTL1: begin
        rd_word[MRA_LSB +: MRA_W]     = cmd.mra;
        rd_word[WD_LSB +: WD_W]       = cmd.wdata;
      end
      SEL_STAT: rd_word[BUSY_BIT]     = busy;
      default:  rd_word               = '0;
    endcase
  end

  // Registered response: captured at the setup edge, shown in the access phase
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata  <= '0;
      pslverr <= 1'b0;
    end else if (setup_ph) begin
      prdata  <= pwrite ? '0 : rd_word;
      pslverr <= (sel == SEL_NONE);
    end else if (access_ph) begin
      prdata  <= '0;
      pslverr <= 1'b0;
    end
  end

  assign unused_wbits = ^{pwdata[30:16], pwdata[3:1], pwdata[7:6]};

endmodule

// File: rtl/mrcmd_issue.sv
module mrcmd_issue (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic req_ack,
  output logic busy,
  output logic req_valid
);

  // launch is gated by !busy upstream, so it never overlaps an open transaction
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      req_valid <= 1'b0;
    end else begin
      req_valid <= launch;
      if (launch)
        busy <= 1'b1;
      else if (busy && req_ack)
        busy <= 1'b0;
    end
  end

endmodule

// File: rtl/mrcmd_frontend.sv
module mrcmd_frontend
  import mrcmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              req_valid,
  output logic              req_is_read,
  output logic [RANK_W-1:0] req_rank,
  output logic [MRA_W-1:0]  req_mr_addr,
  output logic [WD_W-1:0]   req_wdata,
  input  logic              req_ack
);

  mr_cmd_t cmd;
  logic    launch;
  logic    busy;

  mrcmd_csr #(.ADDR_W(ADDR_W)) u_csr (
    .clk     (clk),
    .rst     (rst),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .pwdata  (pwdata),
    .busy    (busy),
    .prdata  (prdata),
    .pslverr (pslverr),
    .cmd     (cmd),
    .launch  (launch)
  );

  mrcmd_issue u_issue (
    .clk       (clk),
    .rst       (rst),
    .launch    (launch),
    .req_ack   (req_ack),
    .busy      (busy),
    .req_valid (req_valid)
  );

  assign pready      = 1'b1;
  assign req_is_read = cmd.is_read;
  assign req_rank    = cmd.rank;
  assign req_mr_addr = cmd.mra;
  assign req_wdata   = cmd.wdata;

endmodule

// File: rtl/mrcmd_chk.sv
module mrcmd_chk
  import mrcmd_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              pslverr,
  input logic              busy,
  input logic              req_valid,
  input logic              req_ack,
  input logic              req_is_read,
  input logic [RANK_W-1:0] req_rank,
  input logic [MRA_W-1:0]  req_mr_addr,
  input logic [WD_W-1:0]   req_wdata
);

  logic acc_wr;
  logic go_wr;
  logic mapped;

  assign acc_wr = psel && penable && pwrite;
  assign go_wr  = acc_wr && (paddr == OFS_CTL0[ADDR_W-1:0]) && pwdata[GO_BIT];
  assign mapped = (paddr == OFS_CTL0[ADDR_W-1:0]) || (paddr == OFS_CTL1[ADDR_W-1:0]) ||
                  (paddr == OFS_STAT[ADDR_W-1:0]);

  // R4
  launch_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (go_wr && !busy) |=> (req_valid && busy));

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R5
  hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !req_ack) |=> (busy && $stable(req_is_read) && $stable(req_rank) &&
                            $stable(req_mr_addr) && $stable(req_wdata)));

  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && req_ack) |=> !busy);

  // R6
  idle_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && req_ack && !go_wr) |=> !busy);

  // R7
  locked_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && acc_wr) |=> !req_valid);

  // R9
  err_phase_chk: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> (psel && penable));

  // R9
  err_map_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && mapped) |-> !pslverr);

endmodule

bind mrcmd_frontend mrcmd_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .pslverr     (pslverr),
  .busy        (busy),
  .req_valid   (req_valid),
  .req_ack     (req_ack),
  .req_is_read (req_is_read),
  .req_rank    (req_rank),
  .req_mr_addr (req_mr_addr),
  .req_wdata   (req_wdata)
);

// File: tb/tb_mrcmd_frontend.sv
module tb_mrcmd_frontend;

  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready, pslverr;
  logic          req_valid, req_is_read, req_ack = 1'b0;
  logic [1:0]    req_rank;
  logic [7:0]    req_mr_addr, req_wdata;

  int tests = 0, fails = 0, strobes = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mrcmd_frontend #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .req_valid(req_valid), .req_is_read(req_is_read),
    .req_rank(req_rank), .req_mr_addr(req_mr_addr), .req_wdata(req_wdata),
    .req_ack(req_ack)
  );

  // Strobe counter sampled away from the active edge
  always @(negedge clk) if (!rst && req_valid) strobes++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    rd = prdata; err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr_reg(input logic [AW-1:0] a, input logic [31:0] d, input logic exp_err, input string req);
    logic [31:0] rd; logic err;
    xfer(1'b1, a, d, rd, err);
    check(req, {31'd0, err}, {31'd0, exp_err});
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] rd; logic err;
    xfer(1'b0, a, 32'd0, rd, err);
    check(req, rd, exp);
  endtask

  task automatic ack_pulse();
    @(negedge clk); req_ack = 1'b1;
    @(negedge clk); req_ack = 1'b0;
  endtask

  initial begin : main
    logic [31:0] rd; logic err;
    int s0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R9 ready
    check("R1 req_valid", {31'd0, req_valid}, 32'd0);
    check("R9 pready", {31'd0, pready}, 32'd1);
    rd_chk(12'h010, 32'd0, "R1 ctl0");
    rd_chk(12'h014, 32'd0, "R1 ctl1");
    rd_chk(12'h018, 32'd0, "R1 stat");

    // R9 unmapped offsets
    xfer(1'b0, 12'h000, 0, rd, err); check("R9 err 0x000", {31'd0, err}, 32'd1);
    xfer(1'b0, 12'h01C, 0, rd, err); check("R9 err 0x01C", {31'd0, err}, 32'd1);
    xfer(1'b0, 12'h011, 0, rd, err); check("R9 err 0x011", {31'd0, err}, 32'd1);
    xfer(1'b0, 12'h110, 0, rd, err); check("R9 err 0x110", {31'd0, err}, 32'd1);
    s0 = strobes;
    wr_reg(12'h00C, 32'hFFFF_FFFF, 1'b1, "R9 err wr");
    rd_chk(12'h010, 32'd0, "R9 unmapped wr ctl0");
    rd_chk(12'h014, 32'd0, "R9 unmapped wr ctl1");
    check("R9 no strobe", strobes - s0, 0);

    // R8 status writes have no effect
    wr_reg(12'h018, 32'hFFFF_FFFF, 1'b0, "R8 err");
    rd_chk(12'h018, 32'd0, "R8 stat after wr");
    check("R8 no strobe", strobes - s0, 0);

    // R6 ack while idle
    ack_pulse();
    rd_chk(12'h018, 32'd0, "R6 idle ack");

    // Sweep: kind x rank x register number
    for (int t = 0; t < 2; t++) begin
      for (int r = 0; r < 4; r++) begin
        for (int k = 0; k < 8; k++) begin
          logic [7:0] mra, wd;
          logic [31:0] c0, c1;
          mra = 8'((k * 37 + r * 11 + t * 101) & 255);
          wd  = 8'((k * 53 + r * 7 + 5) & 255);
          c0  = (32'(r) << 4) | 32'(t);
          c1  = (32'(mra) << 8) | 32'(wd);
          wr_reg(12'h010, c0 | 32'h0000_FFC0, 1'b0, "R2 err");
          rd_chk(12'h010, c0, "R2 ctl0 readback");
          wr_reg(12'h014, c1 | 32'hA5A5_0000, 1'b0, "R3 err");
          rd_chk(12'h014, c1, "R3 ctl1 readback");
          s0 = strobes;
          wr_reg(12'h010, c0 | 32'h8000_0000, 1'b0, "R4 err");
          check("R4 strobe", {31'd0, req_valid}, 32'd1);
          check("R4 fields", {15'd0, req_is_read, req_rank, req_mr_addr, req_wdata},
                {15'd0, 1'(t), 2'(r), mra, wd});
          rd_chk(12'h018, 32'd1, "R8 busy set");
          rd_chk(12'h010, c0, "R2 go reads 0");
          if (k % 2 == 1) begin
            wr_reg(12'h014, ~c1, 1'b0, "R7 err");
            wr_reg(12'h010, 32'h8000_0021 ^ c0, 1'b0, "R7 err");
            rd_chk(12'h014, c1, "R7 ctl1 locked");
            rd_chk(12'h010, c0, "R7 ctl0 locked");
          end
          repeat (k % 3) @(negedge clk);
          check("R5 held", {15'd0, req_is_read, req_rank, req_mr_addr, req_wdata},
                {15'd0, 1'(t), 2'(r), mra, wd});
          ack_pulse();
          rd_chk(12'h018, 32'd0, "R6 busy cleared");
          check("R4 one strobe", strobes - s0, 1);
        end
      end
    end

    // R10 write in the ack cycle is dropped, retry lands
    wr_reg(12'h014, 32'h0000_1234, 1'b0, "R10 err");
    wr_reg(12'h010, 32'h8000_0011, 1'b0, "R10 err");
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h014; pwdata = 32'h0000_5678;
    @(negedge clk);
    penable = 1'b1; req_ack = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; req_ack = 1'b0;
    rd_chk(12'h018, 32'd0, "R10 busy cleared");
    rd_chk(12'h014, 32'h0000_1234, "R10 same-cycle write dropped");
    wr_reg(12'h014, 32'h0000_5678, 1'b0, "R10 err");
    rd_chk(12'h014, 32'h0000_5678, "R10 retry lands");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    done = 1;
    $finish;
  end

  initial begin : watchdog
    #2_000_000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule